// File: doc/BRIEF.md
# I2C Role and Direction Controller

This block holds the two role flags of an I2C engine: whether it drives the bus clock as master or follows as slave, and whether it currently sends or receives data. Software sets either flag through a write strobe with a value. Bus-level events, which arrive as single-cycle pulses from the shift, clock and condition-detect logic next to this block, also update the flags.

A stop condition or a lost arbitration drops the engine back to slave receiver. At the acknowledge slot of the first byte after a start or a repeated start, the direction bit of that address byte sets the transfer direction. A master that sent a read turns into a receiver. A master that sent a write turns into a transmitter. A slave takes the opposite sense from the same bit, but only when its address matched or a general call was seen, and only when the no-acknowledge mode is off.

Each flag has a one-cycle indicator output that pulses when hardware, not software, changed it. All outputs are registered and change one clock after the input pulse that causes them.

Top module: `i2c_role_ctrl`

## Requirements
- R1: After reset, mst_o, trx_o, mst_hw_chg_o and trx_hw_chg_o are all 0.
- R2: A cycle with mst_we_i=1 and no stop or arbitration loss loads mst_wdata_i into mst_o on the next cycle (1 = master, 0 = slave).
- R3: A cycle with trx_we_i=1, no stop or arbitration loss and no direction update loads trx_wdata_i into trx_o on the next cycle (1 = transmitter, 0 = receiver).
- R4: stop_det_i=1 or arb_lost_i=1 forces mst_o and trx_o to 0 on the next cycle. This takes priority over software writes and direction updates in the same cycle.
- R5: In master mode (mst_o=1), an ack_smp_i pulse with ack_lvl_i=0 on the first byte after a start sets trx_o to the inverse of dir_bit_i on the next cycle (dir 1 = read, 0 = write).
- R6: In slave mode (mst_o=0), an ack_smp_i pulse with ack_lvl_i=0 on the first byte, with addr_match_i or gen_call_i high and noack_mode_i=0, sets trx_o to dir_bit_i on the next cycle.
- R7: An ack_smp_i pulse with ack_lvl_i=1 (no acknowledge) and no software write leaves trx_o unchanged.
- R8: In slave mode with noack_mode_i=1, or with neither addr_match_i nor gen_call_i, the direction bit does not change trx_o.
- R9: Only the first ack_smp_i after a start_det_i pulse can update trx_o. Later bytes, and bytes after a stop or arbitration loss without a new start, leave it alone.
- R10: When a direction update and a trx_we_i write happen in the same cycle, the direction update wins.
- R11: mst_hw_chg_o (or trx_hw_chg_o) is high for exactly one cycle, together with the new flag value, when a hardware event changed that flag. It stays low for software writes and for hardware events that leave the value as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mst_we_i | input | 1 | Software write strobe for the master flag |
| mst_wdata_i | input | 1 | Master flag write value |
| trx_we_i | input | 1 | Software write strobe for the transmit flag |
| trx_wdata_i | input | 1 | Transmit flag write value |
| start_det_i | input | 1 | Start or repeated start detected (pulse) |
| stop_det_i | input | 1 | Stop condition detected (pulse) |
| arb_lost_i | input | 1 | Arbitration lost (pulse) |
| ack_smp_i | input | 1 | Acknowledge slot sampled at end of a byte (pulse) |
| ack_lvl_i | input | 1 | Sampled acknowledge level, 0 = acknowledged |
| dir_bit_i | input | 1 | Direction bit of the address byte, 1 = read |
| addr_match_i | input | 1 | Own slave address matched |
| gen_call_i | input | 1 | General call address seen |
| noack_mode_i | input | 1 | No-acknowledge mode, disables slave matching |
| mst_o | output | 1 | 1 = master, 0 = slave |
| trx_o | output | 1 | 1 = transmitter, 0 = receiver |
| mst_hw_chg_o | output | 1 | One-cycle pulse, hardware changed mst_o |
| trx_hw_chg_o | output | 1 | One-cycle pulse, hardware changed trx_o |

## Verification
The assertions take dir_bit_i, ack_lvl_i and the match flags to be valid whenever ack_smp_i pulses. They also take every event input to be a single-cycle pulse sampled on the clock. The random stimulus gives each event its own low probability per cycle, so that starts, byte ends, stops and software writes collide only now and then. Directed cases force the priority collisions of stop against a write and of a direction update against a write. They also force the slave case with no-acknowledge mode on and the second-byte case.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;
  localparam logic MST_RST = 1'b0;
  localparam logic TRX_RST = 1'b0;

  typedef struct packed {
    logic hw_clr;    // stop or arbitration loss
    logic byte_end;  // ack slot sampled
    logic ack_ok;    // ack level low
    logic dir;       // address-byte direction bit, 1 = read
  } role_evt_t;
endpackage

// File: rtl/i2c_role_first_byte.sv
module i2c_role_first_byte
  import i2c_role_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  role_evt_t evt_i,
  output logic      first_o
);
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            first_q <= 1'b0;
    else if (evt_i.hw_clr)  first_q <= 1'b0;
    else if (start_i)       first_q <= 1'b1;
    else if (evt_i.byte_end) first_q <= 1'b0;
  end

  assign first_o = first_q;

  AST_FIRST_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.byte_end && !start_i) |=> !first_o); // R9
endmodule

// File: rtl/i2c_role_mst_reg.sv
module i2c_role_mst_reg
  import i2c_role_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  role_evt_t evt_i,
  input  logic      we_i,
  input  logic      wdata_i,
  output logic      mst_o,
  output logic      chg_o
);
  logic mst_q, mst_d, chg_q;

  always_comb begin
    mst_d = mst_q;
    if (evt_i.hw_clr) mst_d = 1'b0;
    else if (we_i)    mst_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_q <= MST_RST;
      chg_q <= 1'b0;
    end else begin
      mst_q <= mst_d;
      chg_q <= evt_i.hw_clr && mst_q;
    end
  end

  assign mst_o = mst_q;
  assign chg_o = chg_q;

  AST_MST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.hw_clr |=> !mst_o); // R4
  AST_MST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !evt_i.hw_clr) |=> (mst_o == $past(wdata_i))); // R2
  AST_MST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (!mst_o && $past(mst_o))); // R11
endmodule

// File: rtl/i2c_role_trx_reg.sv
module i2c_role_trx_reg
  import i2c_role_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  role_evt_t evt_i,
  input  logic      first_i,
  input  logic      mst_i,
  input  logic      slv_sel_i,
  input  logic      we_i,
  input  logic      wdata_i,
  output logic      trx_o,
  output logic      chg_o
);
  logic trx_q, trx_d, chg_q, dir_upd, dir_val;

  // master flips the sense of the direction bit, slave follows it
  assign dir_upd = evt_i.byte_end && first_i && evt_i.ack_ok && (mst_i || slv_sel_i);
  assign dir_val = mst_i ? ~evt_i.dir : evt_i.dir;

  always_comb begin
    trx_d = trx_q;
    if (evt_i.hw_clr)  trx_d = 1'b0;
    else if (dir_upd)  trx_d = dir_val;
    else if (we_i)     trx_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trx_q <= TRX_RST;
      chg_q <= 1'b0;
    end else begin
      trx_q <= trx_d;
      chg_q <= (evt_i.hw_clr || dir_upd) && (trx_d != trx_q);
    end
  end

  assign trx_o = trx_q;
  assign chg_o = chg_q;

  AST_TRX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.hw_clr |=> !trx_o); // R4
  AST_TRX_NACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.byte_end && !evt_i.ack_ok && !evt_i.hw_clr && !we_i) |=> $stable(trx_o)); // R7
  AST_TRX_LATER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.byte_end && !first_i && !evt_i.hw_clr && !we_i) |=> $stable(trx_o)); // R9
  AST_TRX_NOSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mst_i && !slv_sel_i && !evt_i.hw_clr && !we_i) |=> $stable(trx_o)); // R8
  AST_TRX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (trx_o != $past(trx_o))); // R11
endmodule

// File: rtl/i2c_role_ctrl.sv
module i2c_role_ctrl
  import i2c_role_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mst_we_i,
  input  logic mst_wdata_i,
  input  logic trx_we_i,
  input  logic trx_wdata_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic arb_lost_i,
  input  logic ack_smp_i,
  input  logic ack_lvl_i,
  input  logic dir_bit_i,
  input  logic addr_match_i,
  input  logic gen_call_i,
  input  logic noack_mode_i,
  output logic mst_o,
  output logic trx_o,
  output logic mst_hw_chg_o,
  output logic trx_hw_chg_o
);
  role_evt_t evt;
  logic first_byte, slv_sel, mst_q;

  assign evt.hw_clr   = stop_det_i | arb_lost_i;
  assign evt.byte_end = ack_smp_i;
  assign evt.ack_ok   = ~ack_lvl_i;
  assign evt.dir      = dir_bit_i;
  assign slv_sel      = (addr_match_i | gen_call_i) & ~noack_mode_i;

  i2c_role_first_byte u_first (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_det_i),
    .evt_i   (evt),
    .first_o (first_byte)
  );

  i2c_role_mst_reg u_mst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .we_i    (mst_we_i),
    .wdata_i (mst_wdata_i),
    .mst_o   (mst_q),
    .chg_o   (mst_hw_chg_o)
  );

  i2c_role_trx_reg u_trx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .first_i   (first_byte),
    .mst_i     (mst_q),
    .slv_sel_i (slv_sel),
    .we_i      (trx_we_i),
    .wdata_i   (trx_wdata_i),
    .trx_o     (trx_o),
    .chg_o     (trx_hw_chg_o)
  );

  assign mst_o = mst_q;

  AST_PULSES_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_hw_chg_o && !$past(stop_det_i || arb_lost_i)) |-> 1'b0); // R11
endmodule

// File: tb/i2c_role_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_role_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mst_we, mst_wd, trx_we, trx_wd, start, stop, arb, ack_smp, ack_lvl, dir, amatch, gcall, noack;
  logic mst, trx, mchg, tchg;
  int checks = 0, fails = 0;
  logic e_mst = 0, e_trx = 0, e_first = 0, e_mchg = 0, e_tchg = 0;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_role_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mst_we_i(mst_we), .mst_wdata_i(mst_wd), .trx_we_i(trx_we), .trx_wdata_i(trx_wd),
    .start_det_i(start), .stop_det_i(stop), .arb_lost_i(arb),
    .ack_smp_i(ack_smp), .ack_lvl_i(ack_lvl), .dir_bit_i(dir),
    .addr_match_i(amatch), .gen_call_i(gcall), .noack_mode_i(noack),
    .mst_o(mst), .trx_o(trx), .mst_hw_chg_o(mchg), .trx_hw_chg_o(tchg)
  );

  function automatic logic dir_target(logic m, logic d);
    return m ? !d : d;  // R5 master inverts, R6 slave follows
  endfunction

  task automatic chk(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("mst", mst, e_mst);
    chk("trx", trx, e_trx);
    chk("mst_chg", mchg, e_mchg);
    chk("trx_chg", tchg, e_tchg);
  endtask

  task automatic idle();
    {mst_we, mst_wd, trx_we, trx_wd, start, stop, arb, ack_smp, ack_lvl, dir, amatch, gcall, noack} = '0;
  endtask

  // drive one cycle at negedge, advance expectation, check at next negedge
  task automatic cycle(string t);
    logic clr, upd, n_mst, n_trx, sel;
    tag = t;
    clr = stop | arb;
    sel = e_mst || ((amatch || gcall) && !noack);
    upd = ack_smp && e_first && !ack_lvl && sel;
    n_mst = clr ? 1'b0 : (mst_we ? mst_wd : e_mst);
    n_trx = clr ? 1'b0 : (upd ? dir_target(e_mst, dir) : (trx_we ? trx_wd : e_trx));
    e_mchg = clr && e_mst;
    e_tchg = (clr || upd) && (n_trx != e_trx);
    e_first = clr ? 1'b0 : (start ? 1'b1 : (ack_smp ? 1'b0 : e_first));
    e_mst = n_mst;
    e_trx = n_trx;
    @(negedge clk);
    check_all();
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(negedge clk);
    tag = "R1";
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2 / R3 software writes
    mst_we = 1; mst_wd = 1; cycle("R2");
    trx_we = 1; trx_wd = 1; cycle("R3");
    // R4 stop beats write
    stop = 1; mst_we = 1; mst_wd = 1; trx_we = 1; trx_wd = 1; cycle("R4");
    // R5 master write addressing
    mst_we = 1; mst_wd = 1; cycle("R2");
    start = 1; cycle("R5");
    ack_smp = 1; ack_lvl = 0; dir = 0; cycle("R5");
    // R9 second byte leaves trx
    ack_smp = 1; dir = 1; cycle("R9");
    // R5 repeated start read
    start = 1; cycle("R5");
    ack_smp = 1; dir = 1; cycle("R5");
    // R4 arbitration lost with pulses R11
    arb = 1; cycle("R11");
    // R6 slave matched read
    start = 1; cycle("R6");
    ack_smp = 1; dir = 1; amatch = 1; cycle("R6");
    // R8 noack mode blocks
    start = 1; cycle("R8");
    ack_smp = 1; dir = 0; amatch = 1; noack = 1; cycle("R8");
    // R7 no acknowledge holds
    start = 1; cycle("R7");
    ack_smp = 1; ack_lvl = 1; dir = 0; gcall = 1; cycle("R7");
    // R10 direction update beats write
    start = 1; cycle("R10");
    ack_smp = 1; dir = 0; gcall = 1; trx_we = 1; trx_wd = 1; cycle("R10");

    for (int i = 0; i < 4000; i++) begin
      start   = ($urandom % 8) == 0;
      stop    = ($urandom % 24) == 0;
      arb     = ($urandom % 32) == 0;
      ack_smp = !start && (($urandom % 4) == 0);
      ack_lvl = ($urandom % 5) == 0;
      dir     = $urandom;
      amatch  = $urandom;
      gcall   = ($urandom % 6) == 0;
      noack   = ($urandom % 4) == 0;
      mst_we  = ($urandom % 10) == 0;
      mst_wd  = $urandom;
      trx_we  = ($urandom % 10) == 0;
      trx_wd  = $urandom;
      cycle("R11");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule